// File: doc/BRIEF.md
# PIO timing count calculator

This block turns the timing needs of one programmed-I/O drive into the clock counts that a host-side IDE timing register expects. The inputs are the required address setup time, the required strobe active time and the minimum full cycle time, all in nanoseconds, together with the period of the bus clock. The block divides each time by the clock period and rounds up. It then shapes the counts to fit what the hardware can hold. Recovery takes the larger of two derivations. Short counts are raised to a floor. Any recovery beyond the longest count the hardware can hold moves into the active count. The chip revision selects an offset on the recovery count.

Two drives on one channel can share one set of timing registers. In that case the caller gives the counts already chosen for the other drive. Each result then becomes the slower value of the two. The outputs are the setup count with its 2-bit register code, plus one byte that packs the active and recovery counts. A single start pulse launches a computation. Four sequential dividers run side by side, and a one-cycle done pulse marks the moment every output is valid.

Top module: `pio_timing_calc`

## Requirements
- R1: After a request, `setup_cnt` equals ceil(`setup_ns` / `clk_ns`); `clk_ns` must be nonzero.
- R2: The active count starts as ceil(`active_ns` / `clk_ns`) and is raised to 2 when it is below 2.
- R3: Recovery is the larger of ceil(max(`cycle_ns` - `setup_ns` - `active_ns`, 0) / `clk_ns`) and max(ceil(`cycle_ns`/`clk_ns`) - setup count - active count from R2, 0), then raised to 2 if below 2.
- R4: When recovery from R3 exceeds 17, the surplus over 17 is added to the active count and recovery becomes 17; the active count is then limited to 16.
- R5: When `chip_rev` (2-bit unsigned) is greater than 1, recovery is reduced by 1; for every revision recovery is then limited to 16.
- R6: When `mate_en` is 1, each of the setup, active and recovery results is the larger of this drive's value and `mate_setup`, `mate_active`, `mate_recovery`; when `mate_en` is 0 those inputs have no effect.
- R7: `setup_code` is 2'b00 for a setup count of 4, 2'b10 for 3, 2'b01 for 1 or 2, and 2'b11 for 0 or any count of 5 or more.
- R8: `drw_byte[7:4]` holds the low four bits of the final active count and `drw_byte[3:0]` the low four bits of the final recovery count, so a count of 16 is packed as 0.
- R9: A `start` seen while idle is accepted at that clock edge. `busy` is high from the next cycle. `done` pulses high for exactly one cycle, TIME_W+1 clock edges after the accepting edge, with `busy` low again. The outputs keep their values until the next `done`.
- R10: A `start` seen while `busy` is high is ignored: it yields no extra `done` and does not change the pending results.
- R11: During and right after reset, `done` and `busy` are low and all count, code and byte outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request pulse, sampled when idle |
| setup_ns | input | TIME_W | Required address setup time in ns |
| active_ns | input | TIME_W | Required strobe active time in ns |
| cycle_ns | input | TIME_W | Minimum total cycle time in ns |
| clk_ns | input | CLK_W | Bus clock period in ns, nonzero |
| chip_rev | input | 2 | Controller revision code |
| mate_en | input | 1 | Other drive shares the registers and is present |
| mate_setup | input | TIME_W | Setup count chosen for the other drive |
| mate_active | input | 5 | Active count chosen for the other drive |
| mate_recovery | input | 5 | Recovery count chosen for the other drive |
| busy | output | 1 | Computation in progress |
| done | output | 1 | One-cycle pulse: outputs valid |
| setup_cnt | output | TIME_W | Final setup clock count |
| active_cnt | output | 5 | Final active clock count |
| recovery_cnt | output | 5 | Final recovery clock count |
| setup_code | output | 2 | Encoded setup field |
| drw_byte | output | 8 | Packed active/recovery byte |

## Verification
The bench uses the defaults TIME_W=10 and CLK_W=8. Times therefore run up to 1023 ns and clock periods up to 255 ns, and the done pulse comes 11 edges after start. Short clock periods against long cycle times give recoveries far above 17, so the spill into active and the active limit of 16 both come into play. Periods close to the setup and active times push counts under the floor of 2 and steer the setup count across every code boundary. A random sweep over revisions and shared-register values checks the result against an integer model on every clock.

// File: rtl/pio_calc_pkg.sv
package pio_calc_pkg;

    localparam int unsigned REG_CNT_W = 5;
    localparam int unsigned CNT_FLOOR = 2;
    localparam int unsigned REC_SPILL = 17;
    localparam int unsigned ACT_LIMIT = 16;
    localparam int unsigned REC_LIMIT = 16;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } calc_state_e;

    typedef struct packed {
        logic [REG_CNT_W-1:0] active;
        logic [REG_CNT_W-1:0] recovery;
    } drw_pair_t;

    typedef struct packed {
        logic [1:0] rev;
        logic       mate_en;
        drw_pair_t  mate_drw;
    } calc_ctx_t;

    // Register code for the address setup count.
    function automatic logic [1:0] setup_encode(input logic [31:0] cnt);
        logic [1:0] code;
        case (cnt)
            32'd4:        code = 2'b00;
            32'd3:        code = 2'b10;
            32'd1, 32'd2: code = 2'b01;
            default:      code = 2'b11;
        endcase
        return code;
    endfunction

    // Active count in the high nibble, recovery in the low nibble.
    function automatic logic [7:0] pack_drw(input drw_pair_t p);
        logic [3:0] hi;
        logic [3:0] lo;
        hi = 4'(p.active);
        lo = 4'(p.recovery);
        return {hi, lo};
    endfunction

endpackage

// File: rtl/pio_ceil_div.sv
module pio_ceil_div #(
    parameter int unsigned NUM_W = 10,
    parameter int unsigned DEN_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [NUM_W-1:0] num,
    input  logic [DEN_W-1:0] den,
    output logic             valid,
    output logic [NUM_W-1:0] quot_ceil
);
    localparam int unsigned STEP_W = $clog2(NUM_W + 1);
    localparam int unsigned REM_W  = DEN_W + 1;
    localparam int unsigned TRY_W  = DEN_W + 2;

    logic [REM_W-1:0]  rem_q;
    logic [NUM_W-1:0]  quo_q;
    logic [DEN_W-1:0]  den_q;
    logic [STEP_W-1:0] step_q;
    logic              run_q;
    logic              valid_q;

    logic [TRY_W-1:0]  shifted;
    logic [TRY_W-1:0]  trial;
    logic              take;
    logic [REM_W-1:0]  rem_nx;

    always_comb begin
        shifted = {rem_q, quo_q[NUM_W-1]};
        take    = (shifted >= TRY_W'(den_q));
        trial   = shifted - TRY_W'(den_q);
        rem_nx  = take ? REM_W'(trial) : REM_W'(shifted);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rem_q   <= '0;
            quo_q   <= '0;
            den_q   <= '0;
            step_q  <= '0;
            run_q   <= 1'b0;
            valid_q <= 1'b0;
        end else begin
            valid_q <= 1'b0;
            if (start && !run_q) begin
                rem_q  <= '0;
                quo_q  <= num;
                den_q  <= den;
                step_q <= STEP_W'(NUM_W);
                run_q  <= 1'b1;
            end else if (run_q) begin
                rem_q  <= rem_nx;
                quo_q  <= {quo_q[NUM_W-2:0], take};
                step_q <= step_q - 1'b1;
                if (step_q == STEP_W'(1)) begin
                    run_q   <= 1'b0;
                    valid_q <= 1'b1;
                end
            end
        end
    end

    assign valid     = valid_q;
    assign quot_ceil = quo_q + NUM_W'(rem_q != '0);

endmodule

// File: rtl/pio_count_shaper.sv
module pio_count_shaper
    import pio_calc_pkg::*;
#(
    parameter int unsigned CNT_W = 10
) (
    input  logic [CNT_W-1:0] setup_q,
    input  logic [CNT_W-1:0] active_q,
    input  logic [CNT_W-1:0] rec_q,
    input  logic [CNT_W-1:0] cycle_q,
    input  logic [CNT_W-1:0] mate_setup,
    input  calc_ctx_t        ctx,
    output logic [CNT_W-1:0] setup_out,
    output drw_pair_t        drw_out
);
    localparam int unsigned EXT_W = CNT_W + 2;

    logic [EXT_W-1:0] set_e, act_e, rec_e, cyc_e;
    logic [EXT_W-1:0] act_min, base_sum, rec_alt, rec_pick, rec_min;
    logic [EXT_W-1:0] act_sp, rec_sp, act_cap, rec_adj, rec_cap;
    logic [EXT_W-1:0] m_set, m_act, m_rec;
    logic [EXT_W-1:0] fin_set, fin_act, fin_rec;

    always_comb begin
        set_e = EXT_W'(setup_q);
        act_e = EXT_W'(active_q);
        rec_e = EXT_W'(rec_q);
        cyc_e = EXT_W'(cycle_q);

        act_min  = (act_e < EXT_W'(CNT_FLOOR)) ? EXT_W'(CNT_FLOOR) : act_e;
        base_sum = set_e + act_min;
        rec_alt  = (cyc_e > base_sum) ? (cyc_e - base_sum) : '0;
        rec_pick = (rec_e > rec_alt) ? rec_e : rec_alt;
        rec_min  = (rec_pick < EXT_W'(CNT_FLOOR)) ? EXT_W'(CNT_FLOOR) : rec_pick;

        if (rec_min > EXT_W'(REC_SPILL)) begin
            act_sp = act_min + rec_min - EXT_W'(REC_SPILL);
            rec_sp = EXT_W'(REC_SPILL);
        end else begin
            act_sp = act_min;
            rec_sp = rec_min;
        end

        act_cap = (act_sp > EXT_W'(ACT_LIMIT)) ? EXT_W'(ACT_LIMIT) : act_sp;
        rec_adj = (ctx.rev > 2'd1) ? (rec_sp - 1'b1) : rec_sp;
        rec_cap = (rec_adj > EXT_W'(REC_LIMIT)) ? EXT_W'(REC_LIMIT) : rec_adj;

        m_set = EXT_W'(mate_setup);
        m_act = EXT_W'(ctx.mate_drw.active);
        m_rec = EXT_W'(ctx.mate_drw.recovery);

        fin_set = (ctx.mate_en && m_set > set_e)   ? m_set : set_e;
        fin_act = (ctx.mate_en && m_act > act_cap) ? m_act : act_cap;
        fin_rec = (ctx.mate_en && m_rec > rec_cap) ? m_rec : rec_cap;
    end

    assign setup_out        = CNT_W'(fin_set);
    assign drw_out.active   = REG_CNT_W'(fin_act);
    assign drw_out.recovery = REG_CNT_W'(fin_rec);

endmodule

// File: rtl/pio_timing_calc.sv
module pio_timing_calc
    import pio_calc_pkg::*;
#(
    parameter int unsigned TIME_W = 10,
    parameter int unsigned CLK_W  = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [TIME_W-1:0] setup_ns,
    input  logic [TIME_W-1:0] active_ns,
    input  logic [TIME_W-1:0] cycle_ns,
    input  logic [CLK_W-1:0]  clk_ns,
    input  logic [1:0]        chip_rev,
    input  logic              mate_en,
    input  logic [TIME_W-1:0] mate_setup,
    input  logic [4:0]        mate_active,
    input  logic [4:0]        mate_recovery,
    output logic              busy,
    output logic              done,
    output logic [TIME_W-1:0] setup_cnt,
    output logic [4:0]        active_cnt,
    output logic [4:0]        recovery_cnt,
    output logic [1:0]        setup_code,
    output logic [7:0]        drw_byte
);
    localparam int unsigned N_DIV = 4;
    localparam int unsigned SUM_W = TIME_W + 2;

    calc_state_e       state_q;
    logic              accept;
    logic [SUM_W-1:0]  sa_sum;
    logic [TIME_W-1:0] rec_ns;
    logic [TIME_W-1:0] div_num [N_DIV];
    logic [TIME_W-1:0] q_ceil  [N_DIV];
    logic [N_DIV-1:0]  div_valid;
    logic              all_valid;

    calc_ctx_t         ctx_q;
    logic [TIME_W-1:0] mate_setup_q;
    logic [TIME_W-1:0] shaped_setup;
    drw_pair_t         shaped_drw;

    logic [TIME_W-1:0] setup_cnt_q;
    drw_pair_t         drw_q;
    logic [1:0]        code_q;
    logic [7:0]        byte_q;
    logic              done_q;

    assign accept = start && (state_q == ST_IDLE);

    always_comb begin
        sa_sum = SUM_W'(setup_ns) + SUM_W'(active_ns);
        rec_ns = (SUM_W'(cycle_ns) > sa_sum) ? TIME_W'(SUM_W'(cycle_ns) - sa_sum) : '0;
    end

    assign div_num[0] = setup_ns;
    assign div_num[1] = active_ns;
    assign div_num[2] = rec_ns;
    assign div_num[3] = cycle_ns;

    for (genvar gi = 0; gi < N_DIV; gi++) begin : g_div
        pio_ceil_div #(
            .NUM_W(TIME_W),
            .DEN_W(CLK_W)
        ) u_div (
            .clk      (clk),
            .rst      (rst),
            .start    (accept),
            .num      (div_num[gi]),
            .den      (clk_ns),
            .valid    (div_valid[gi]),
            .quot_ceil(q_ceil[gi])
        );
    end

    assign all_valid = &div_valid;

    pio_count_shaper #(
        .CNT_W(TIME_W)
    ) u_shape (
        .setup_q   (q_ceil[0]),
        .active_q  (q_ceil[1]),
        .rec_q     (q_ceil[2]),
        .cycle_q   (q_ceil[3]),
        .mate_setup(mate_setup_q),
        .ctx       (ctx_q),
        .setup_out (shaped_setup),
        .drw_out   (shaped_drw)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q      <= ST_IDLE;
            ctx_q        <= '0;
            mate_setup_q <= '0;
            setup_cnt_q  <= '0;
            drw_q        <= '0;
            code_q       <= '0;
            byte_q       <= '0;
            done_q       <= 1'b0;
        end else begin
            done_q <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (accept) begin
                        ctx_q.rev               <= chip_rev;
                        ctx_q.mate_en           <= mate_en;
                        ctx_q.mate_drw.active   <= mate_active;
                        ctx_q.mate_drw.recovery <= mate_recovery;
                        mate_setup_q            <= mate_setup;
                        state_q                 <= ST_RUN;
                    end
                end
                ST_RUN: begin
                    if (all_valid) begin
                        setup_cnt_q <= shaped_setup;
                        drw_q       <= shaped_drw;
                        code_q      <= setup_encode(32'(shaped_setup));
                        byte_q      <= pack_drw(shaped_drw);
                        done_q      <= 1'b1;
                        state_q     <= ST_IDLE;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign busy         = (state_q == ST_RUN);
    assign done         = done_q;
    assign setup_cnt    = setup_cnt_q;
    assign active_cnt   = drw_q.active;
    assign recovery_cnt = drw_q.recovery;
    assign setup_code   = code_q;
    assign drw_byte     = byte_q;

endmodule

// File: rtl/pio_timing_calc_chk.sv
module pio_timing_calc_chk #(
    parameter int unsigned TIME_W = 10
) (
    input logic              clk,
    input logic              rst,
    input logic              start,
    input logic              busy,
    input logic              done,
    input logic [TIME_W-1:0] setup_cnt,
    input logic [4:0]        active_cnt,
    input logic [4:0]        recovery_cnt,
    input logic [1:0]        setup_code,
    input logic [7:0]        drw_byte,
    input logic              ctx_mate_en,
    input logic [TIME_W-1:0] ctx_mate_setup,
    input logic [4:0]        ctx_mate_active,
    input logic [4:0]        ctx_mate_rec
);

    a_r9_done_single: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    a_r9_busy_from_start: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(start));

    a_r10_done_after_busy: assert property (@(posedge clk) disable iff (rst)
        done |-> ($past(busy) && !busy));

    a_r4_active_window: assert property (@(posedge clk) disable iff (rst)
        (done && !ctx_mate_en) |-> (active_cnt >= 5'd2 && active_cnt <= 5'd16));

    a_r5_recovery_window: assert property (@(posedge clk) disable iff (rst)
        (done && !ctx_mate_en) |-> (recovery_cnt >= 5'd1 && recovery_cnt <= 5'd16));

    a_r6_merge_slowest: assert property (@(posedge clk) disable iff (rst)
        (done && ctx_mate_en) |-> (active_cnt >= ctx_mate_active &&
                                   recovery_cnt >= ctx_mate_rec &&
                                   setup_cnt >= ctx_mate_setup));

    a_r7_code_four: assert property (@(posedge clk) disable iff (rst)
        done |-> ((setup_cnt == TIME_W'(4)) == (setup_code == 2'b00)));

    a_r9_outputs_hold: assert property (@(posedge clk) disable iff (rst)
        !done |-> ($stable(drw_byte) && $stable(setup_cnt) && $stable(setup_code)));

endmodule

bind pio_timing_calc pio_timing_calc_chk #(
    .TIME_W(TIME_W)
) u_chk (
    .clk            (clk),
    .rst            (rst),
    .start          (start),
    .busy           (busy),
    .done           (done),
    .setup_cnt      (setup_cnt),
    .active_cnt     (active_cnt),
    .recovery_cnt   (recovery_cnt),
    .setup_code     (setup_code),
    .drw_byte       (drw_byte),
    .ctx_mate_en    (ctx_q.mate_en),
    .ctx_mate_setup (mate_setup_q),
    .ctx_mate_active(ctx_q.mate_drw.active),
    .ctx_mate_rec   (ctx_q.mate_drw.recovery)
);

// File: tb/pio_timing_calc_bench.sv
module pio_timing_calc_bench;
    localparam int CLK_PERIOD = 10;
    localparam int TW  = 10;
    localparam int CW  = 8;
    localparam int LAT = TW + 1;
    localparam int WATCHDOG = 150000;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          start = 1'b0;
    logic [TW-1:0] setup_ns = '0, active_ns = '0, cycle_ns = '0;
    logic [CW-1:0] clk_ns = 8'd30;
    logic [1:0]    chip_rev = '0;
    logic          mate_en = 1'b0;
    logic [TW-1:0] mate_setup = '0;
    logic [4:0]    mate_active = '0, mate_recovery = '0;
    logic          busy, done;
    logic [TW-1:0] setup_cnt;
    logic [4:0]    active_cnt, recovery_cnt;
    logic [1:0]    setup_code;
    logic [7:0]    drw_byte;

    int n_checks = 0;
    int n_fail   = 0;
    int cyc_cnt  = 0;
    bit finished = 0;

    pio_timing_calc #(.TIME_W(TW), .CLK_W(CW)) u_pio_timing_calc (
        .clk(clk), .rst(rst), .start(start),
        .setup_ns(setup_ns), .active_ns(active_ns), .cycle_ns(cycle_ns),
        .clk_ns(clk_ns), .chip_rev(chip_rev), .mate_en(mate_en),
        .mate_setup(mate_setup), .mate_active(mate_active),
        .mate_recovery(mate_recovery), .busy(busy), .done(done),
        .setup_cnt(setup_cnt), .active_cnt(active_cnt),
        .recovery_cnt(recovery_cnt), .setup_code(setup_code),
        .drw_byte(drw_byte)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        cyc_cnt++;
        if (cyc_cnt > WATCHDOG) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc_cnt, WATCHDOG);
            finish_run();
        end
    end

    function automatic int cdiv(input int x, input int d);
        return (x + d - 1) / d;
    endfunction

    // Integer model straight from the requirements.
    function automatic void model(input int s, input int a, input int c, input int k,
                                  input int rev, input int me, input int ms,
                                  input int ma, input int mr,
                                  output int os, output int oa, output int orc,
                                  output int ocode, output int opk);
        int rt, r1, r2, cc;
        os = cdiv(s, k);
        oa = cdiv(a, k);
        if (oa < 2) oa = 2;
        rt = c - s - a;
        if (rt < 0) rt = 0;
        r1 = cdiv(rt, k);
        cc = cdiv(c, k);
        r2 = cc - os - oa;
        if (r2 < 0) r2 = 0;
        orc = (r1 > r2) ? r1 : r2;
        if (orc < 2) orc = 2;
        if (orc > 17) begin
            oa  = oa + orc - 17;
            orc = 17;
        end
        if (oa > 16) oa = 16;
        if (rev > 1) orc = orc - 1;
        if (orc > 16) orc = 16;
        if (me != 0) begin
            if (ms > os)  os  = ms;
            if (ma > oa)  oa  = ma;
            if (mr > orc) orc = mr;
        end
        if (os == 4) ocode = 0;
        else if (os == 3) ocode = 2;
        else if (os == 1 || os == 2) ocode = 1;
        else ocode = 3;
        opk = ((oa % 16) * 16) + (orc % 16);
    endfunction

    task automatic apply(input int s, input int a, input int c, input int k,
                         input int rev, input int me, input int ms,
                         input int ma, input int mr);
        setup_ns = TW'(s); active_ns = TW'(a); cycle_ns = TW'(c);
        clk_ns = CW'(k); chip_rev = 2'(rev); mate_en = me[0];
        mate_setup = TW'(ms); mate_active = 5'(ma); mate_recovery = 5'(mr);
    endtask

    // One request; called at a falling edge while idle.
    task automatic run(input string tag, input int s, input int a, input int c,
                       input int k, input int rev, input int me, input int ms,
                       input int ma, input int mr, input bit poke);
        int es, ea, er, ec, ep;
        model(s, a, c, k, rev, me, ms, ma, mr, es, ea, er, ec, ep);
        apply(s, a, c, k, rev, me, ms, ma, mr);
        start = 1'b1;
        @(posedge clk); @(negedge clk);
        start = 1'b0;
        apply(1000, 900, 50, 3, 3 - rev, 1, 900, 31, 31);
        for (int cyc = 1; cyc <= LAT; cyc++) begin
            if (poke && cyc == 3) start = 1'b1;
            @(posedge clk); @(negedge clk);
            start = 1'b0;
            if (cyc < LAT) begin
                check("R9 done too early", int'(done), 0);
                check("R9 busy while running", int'(busy), 1);
            end else begin
                check("R9 done at latency", int'(done), 1);
                check("R9 busy cleared", int'(busy), 0);
                check({tag, " R1 setup_cnt"}, int'(setup_cnt), es);
                check({tag, " R2 active_cnt"}, int'(active_cnt), ea);
                check({tag, " R3 recovery_cnt"}, int'(recovery_cnt), er);
                check({tag, " R7 setup_code"}, int'(setup_code), ec);
                check({tag, " R8 drw_byte"}, int'(drw_byte), ep);
            end
        end
        for (int cyc = 0; cyc < (poke ? LAT + 2 : 1); cyc++) begin
            @(posedge clk); @(negedge clk);
            check(poke ? "R10 no extra done" : "R9 single pulse", int'(done), 0);
            check("R9 byte held", int'(drw_byte), ep);
        end
    endtask

    initial begin
        @(negedge clk); @(negedge clk); @(negedge clk);
        check("R11 done in reset", int'(done), 0);
        check("R11 busy in reset", int'(busy), 0);
        rst = 1'b0;
        @(negedge clk);
        check("R11 done after reset", int'(done), 0);
        check("R11 busy after reset", int'(busy), 0);
        check("R11 setup_cnt after reset", int'(setup_cnt), 0);
        check("R11 drw_byte after reset", int'(drw_byte), 0);
        check("R11 setup_code after reset", int'(setup_code), 0);

        run("R1", 70, 165, 600, 30, 1, 0, 0, 0, 0, 0);   // 3/6/13, 0x6D
        run("R5", 70, 165, 600, 30, 2, 0, 0, 0, 0, 0);   // recovery 12
        run("R2", 25, 20, 90, 30, 2, 0, 0, 0, 0, 0);     // active floor
        run("R3", 100, 100, 150, 30, 0, 0, 0, 0, 0, 0);  // negative recovery time
        run("R4", 30, 60, 900, 30, 0, 0, 0, 0, 0, 0);    // spill, 0xC0
        run("R4", 70, 165, 600, 10, 3, 0, 0, 0, 0, 0);   // active limit
        run("R6", 70, 165, 600, 30, 1, 1, 5, 8, 4, 0);   // merged
        run("R6", 70, 165, 600, 30, 1, 0, 9, 15, 15, 0); // mate ignored
        run("R7", 80, 100, 400, 20, 1, 0, 0, 0, 0, 0);   // setup 4
        run("R7", 0, 100, 400, 20, 1, 0, 0, 0, 0, 0);    // setup 0
        run("R7", 40, 100, 400, 20, 1, 0, 0, 0, 0, 0);   // setup 2
        run("R7", 60, 100, 400, 20, 1, 0, 0, 0, 0, 0);   // setup 3
        run("R10", 70, 165, 600, 30, 2, 0, 0, 0, 0, 1);  // start while busy
        for (int i = 0; i < 40; i++) begin
            run("R3 sweep", $urandom_range(0, 250), $urandom_range(0, 400),
                $urandom_range(0, 1023), $urandom_range(1, 80),
                $urandom_range(0, 3), $urandom_range(0, 1),
                $urandom_range(0, 8), $urandom_range(2, 16),
                $urandom_range(1, 16), (i % 7) == 3);
        end
        finish_run();
    end

endmodule